// File: doc/BRIEF.md
# I2C Master Bus Timing Generator

This block produces the SCL and SDA pull-down enables for an I2C master. It times every bus condition from the system clock. One SCL period spans P system clock cycles, where P is picked by a three-bit divisor select, and H = P/2 is the half period. Each interval the block produces is a half or a full SCL period, adjusted by a few system clock cycles where the bus timing calls for it.

A sequencer issues one of four commands through single-cycle strobes: start, repeated start, single-bit write and stop. Both lines are open-drain style. The block only ever pulls a line low or releases it. While a sequence runs, the block holds `busy` high. It raises `done` for one cycle when the sequence ends. Commands are sampled only while the block is idle. A start expects a released bus. The other three commands expect SCL to be held low, as a previous start or bit leaves it.

Top module: `i2c_master_timing`

## Requirements
- R1: While reset is low, and after it is released, both pull-down enables are 0 (line released), `busy` is 0 and `done` is 0. Asserting reset in the middle of a sequence returns the block to that state at once.
- R2: Divisor select values 0, 1, 2, 3 and 4 choose the divisor parameters DIV0..DIV4, with defaults 200, 224, 48, 56 and 80. Values 5 to 7 fall back to DIV0. The half period is H = P/2.
- R3: For a start accepted at clock edge E, both lines stay released until E+H-1, which gives the bus free time. SDA is pulled low at E+H-1. SCL is pulled low at E+2H-2, which gives a start hold of H-1 cycles.
- R4: For a bit write accepted at E, SDA holds its value until E+3 (data hold). At E+3, SDA is pulled low for a 0 bit and released for a 1 bit. SCL is released at E+H, which gives a data setup of H-3 cycles. SCL is pulled low again at E+2H.
- R5: For a repeated start accepted at E, SDA is released at E+3 and SCL is released at E+H. SDA falls at E+H+P, after SCL has been high for one full period. SCL falls at E+2H+P-1.
- R6: For a stop accepted at E, SDA is pulled low at E+3 and SCL is released at E+H. SDA is released at E+2H+2, which is H+2 cycles after SCL rose.
- R7: `busy` is 1 from the cycle after a command is accepted until the cycle in which `done` is 1. `done` is high for exactly one cycle per sequence, and `busy` is 0 in that cycle.
- R8: A command strobe raised while `busy` is 1 is ignored. The running sequence keeps its timing and produces a single `done`.
- R9: A change of divisor select while `busy` is 1 has no effect on the running sequence. The select is sampled when the command is accepted.
- R10: When several strobes are high in the same idle cycle, start wins over repeated start, repeated start wins over write, and write wins over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 3 | SCL divisor select |
| cmdStart | input | 1 | Start command strobe |
| cmdRestart | input | 1 | Repeated start command strobe |
| cmdWrite | input | 1 | Single-bit write command strobe |
| cmdStop | input | 1 | Stop command strobe |
| wrBit | input | 1 | Bit value for a write, sampled with the command |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench keeps the default divisors 200, 224, 48 and 56 and overrides DIV4 to 10. With H = 5, the data setup window is only two cycles, and the derived offsets sit next to one another. The 48 and 56 settings give short runs through every command type, and the 200 and 224 settings give full-size counts. Select 7 shows the fallback to DIV0. Changing the select mid-sequence, from 48 to 200, makes any leak of the new value show up clearly in the edge timing.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

  // Cycles SDA is held after SCL falls before it may change
  localparam int unsigned DATA_HOLD_CYC = 3;

  // Which interval length the counter loads
  typedef enum logic [2:0] {
    LEN_HALF_M1,
    LEN_HOLD,
    LEN_HALF_M3,
    LEN_HALF,
    LEN_FULL,
    LEN_HALF_P2
  } lenSel_e;

  // Control-to-datapath strobes, applied on the next clock edge
  typedef struct packed {
    logic    load;
    lenSel_e len;
    logic    latchBit;
    logic    sclPull;
    logic    sclFree;
    logic    sdaPull;
    logic    sdaFree;
    logic    sdaFromBit;
    logic    fireDone;
  } strobe_t;

  function automatic int unsigned largestOf(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d,
                                            input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/i2ct_datapath.sv
`timescale 1ns/1ps
module i2ct_datapath import i2ct_pkg::*; #(
  parameter int unsigned DIV0  = 200,
  parameter int unsigned DIV1  = 224,
  parameter int unsigned DIV2  = 48,
  parameter int unsigned DIV3  = 56,
  parameter int unsigned DIV4  = 80,
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] divSel,
  input  logic       wrBit,
  input  logic       latchDiv,
  input  logic       busy,
  input  strobe_t    stb,
  output logic       cntZero,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       done
);

  logic [CNT_W-1:0] divQ, effDiv, half, lenVal, cnt;
  logic             bitQ;

  function automatic logic [CNT_W-1:0] decodeDiv(input logic [2:0] sel);
    case (sel)
      3'd1:    return CNT_W'(DIV1);
      3'd2:    return CNT_W'(DIV2);
      3'd3:    return CNT_W'(DIV3);
      3'd4:    return CNT_W'(DIV4);
      default: return CNT_W'(DIV0);
    endcase
  endfunction

  // While idle the live select is used, so the first load sees it
  assign effDiv = latchDiv ? decodeDiv(divSel) : divQ;
  assign half   = effDiv >> 1;

  always_comb begin
    case (stb.len)
      LEN_HALF_M1: lenVal = half - CNT_W'(1);
      LEN_HOLD:    lenVal = CNT_W'(DATA_HOLD_CYC);
      LEN_HALF_M3: lenVal = half - CNT_W'(DATA_HOLD_CYC);
      LEN_HALF:    lenVal = half;
      LEN_FULL:    lenVal = effDiv;
      LEN_HALF_P2: lenVal = half + CNT_W'(2);
      default:     lenVal = half;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= CNT_W'(DIV0);
      bitQ <= 1'b1;
    end else begin
      if (latchDiv)     divQ <= decodeDiv(divSel);
      if (stb.latchBit) bitQ <= wrBit;
    end
  end

  // Interval counter: a load of L makes the phase last L cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (stb.load)    cnt <= lenVal - CNT_W'(1);
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLow <= 1'b0;
      sdaLow <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (stb.sclPull)         sclLow <= 1'b1;
      else if (stb.sclFree)    sclLow <= 1'b0;
      if (stb.sdaFromBit)      sdaLow <= ~bitQ;
      else if (stb.sdaPull)    sdaLow <= 1'b1;
      else if (stb.sdaFree)    sdaLow <= 1'b0;
      done <= stb.fireDone;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= divQ + CNT_W'(1)); // R2

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(divQ)); // R9

endmodule

// File: rtl/i2ct_ctrl.sv
`timescale 1ns/1ps
module i2ct_ctrl import i2ct_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdStart,
  input  logic    cmdRestart,
  input  logic    cmdWrite,
  input  logic    cmdStop,
  input  logic    cntZero,
  output strobe_t stb,
  output logic    busy,
  output logic    latchDiv
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUSFREE, ST_STARTHOLD, ST_DHOLD, ST_SETUP, ST_SCLHIGH, ST_RSSETUP, ST_STOPSETUP
  } state_e;

  typedef enum logic [1:0] {OP_START, OP_RESTART, OP_WRITE, OP_STOP} op_e;

  state_e state, stateNext;
  op_e    opQ, opNext;
  logic   anyCmd;

  assign anyCmd = cmdStart | cmdRestart | cmdWrite | cmdStop;

  always_comb begin
    stb       = '0;
    stateNext = state;
    opNext    = opQ;
    case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          opNext = OP_START;  stb.load = 1'b1; stb.len = LEN_HALF_M1; stateNext = ST_BUSFREE;
        end else if (anyCmd) begin
          opNext = cmdRestart ? OP_RESTART : (cmdWrite ? OP_WRITE : OP_STOP);
          stb.load = 1'b1; stb.len = LEN_HOLD; stb.latchBit = cmdWrite & ~cmdRestart;
          stateNext = ST_DHOLD;
        end
      end
      ST_BUSFREE: if (cntZero) begin
        stb.sdaPull = 1'b1; stb.load = 1'b1; stb.len = LEN_HALF_M1; stateNext = ST_STARTHOLD;
      end
      ST_STARTHOLD: if (cntZero) begin
        stb.sclPull = 1'b1; stb.fireDone = 1'b1; stateNext = ST_IDLE;
      end
      ST_DHOLD: if (cntZero) begin
        stb.load = 1'b1; stb.len = LEN_HALF_M3; stateNext = ST_SETUP;
        case (opQ)
          OP_WRITE:   stb.sdaFromBit = 1'b1;
          OP_RESTART: stb.sdaFree    = 1'b1;
          default:    stb.sdaPull    = 1'b1;
        endcase
      end
      ST_SETUP: if (cntZero) begin
        stb.sclFree = 1'b1; stb.load = 1'b1;
        case (opQ)
          OP_WRITE:   begin stb.len = LEN_HALF;    stateNext = ST_SCLHIGH;   end
          OP_RESTART: begin stb.len = LEN_FULL;    stateNext = ST_RSSETUP;   end
          default:    begin stb.len = LEN_HALF_P2; stateNext = ST_STOPSETUP; end
        endcase
      end
      ST_SCLHIGH: if (cntZero) begin
        stb.sclPull = 1'b1; stb.fireDone = 1'b1; stateNext = ST_IDLE;
      end
      ST_RSSETUP: if (cntZero) begin
        stb.sdaPull = 1'b1; stb.load = 1'b1; stb.len = LEN_HALF_M1; stateNext = ST_STARTHOLD;
      end
      ST_STOPSETUP: if (cntZero) begin
        stb.sdaFree = 1'b1; stb.fireDone = 1'b1; stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_START;
    end else begin
      state <= stateNext;
      opQ   <= opNext;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign latchDiv = (state == ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.fireDone |=> !stb.fireDone); // R7

  AST_CMD_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyCmd && !cntZero) |=> (opQ == $past(opQ))); // R8

endmodule

// File: rtl/i2c_master_timing.sv
`timescale 1ns/1ps
module i2c_master_timing import i2ct_pkg::*; #(
  parameter int unsigned DIV0 = 200,
  parameter int unsigned DIV1 = 224,
  parameter int unsigned DIV2 = 48,
  parameter int unsigned DIV3 = 56,
  parameter int unsigned DIV4 = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] divSel,
  input  logic       cmdStart,
  input  logic       cmdRestart,
  input  logic       cmdWrite,
  input  logic       cmdStop,
  input  logic       wrBit,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       busy,
  output logic       done
);

  localparam int unsigned MAX_DIV = largestOf(DIV0, DIV1, DIV2, DIV3, DIV4);
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 3);

  strobe_t stb;
  logic    cntZero, latchDiv, anyCmd;

  assign anyCmd = cmdStart | cmdRestart | cmdWrite | cmdStop;

  i2ct_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .cmdRestart (cmdRestart),
    .cmdWrite   (cmdWrite),
    .cmdStop    (cmdStop),
    .cntZero    (cntZero),
    .stb        (stb),
    .busy       (busy),
    .latchDiv   (latchDiv)
  );

  i2ct_datapath #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .DIV4(DIV4), .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .divSel   (divSel),
    .wrBit    (wrBit),
    .latchDiv (latchDiv),
    .busy     (busy),
    .stb      (stb),
    .cntZero  (cntZero),
    .sclLow   (sclDriveLow),
    .sdaLow   (sdaDriveLow),
    .done     (done)
  );

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyCmd) |=> ($stable(sclDriveLow) && $stable(sdaDriveLow) && !busy)); // R8

endmodule

// File: tb/i2c_master_timing_tb.sv
`timescale 1ns/1ps
module i2c_master_timing_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] divSel = 3'd0;
  logic       cmdStart = 1'b0, cmdRestart = 1'b0, cmdWrite = 1'b0, cmdStop = 1'b0, wrBit = 1'b0;
  logic       sclDriveLow, sdaDriveLow, busy, done;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_master_timing #(.DIV4(10)) u_dut (
    .clk(clk), .rstN(rstN), .divSel(divSel),
    .cmdStart(cmdStart), .cmdRestart(cmdRestart), .cmdWrite(cmdWrite), .cmdStop(cmdStop),
    .wrBit(wrBit), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done)
  );

  // op: 0 start, 1 restart, 2 write, 3 stop; fields {op, bit, sel}
  localparam logic [6:0] VEC [0:9] = '{
    {3'd0, 1'b0, 3'd2},   // start, period 48
    {3'd2, 1'b0, 3'd2},   // write 0, SDA already low
    {3'd2, 1'b1, 3'd4},   // write 1, period 10
    {3'd2, 1'b0, 3'd4},   // write 0
    {3'd1, 1'b0, 3'd3},   // repeated start, period 56
    {3'd2, 1'b1, 3'd3},   // write 1
    {3'd3, 1'b0, 3'd4},   // stop, period 10
    {3'd0, 1'b0, 3'd0},   // start, period 200
    {3'd2, 1'b1, 3'd1},   // write 1, period 224
    {3'd3, 1'b0, 3'd7}    // stop, select 7 falls back to 200
  };

  function automatic int benchDiv(input logic [2:0] sel);
    case (sel)
      3'd1: return 224;
      3'd2: return 48;
      3'd3: return 56;
      3'd4: return 10;
      default: return 200;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Times are posedges counted from the strobe; an edge at E+x is seen as x+1
  task automatic expectTimes(input int op, input int h, input int p, input logic prevSda, input logic b,
                             output int sF, output int sL, output int cF, output int cL, output int dT,
                             output logic eScl, output logic eSda);
    case (op)
      0: begin sF = h; sL = h; cF = 2*h-1; cL = 2*h-1; dT = 2*h-1; eScl = 1; eSda = 1; end
      1: begin
        sF = prevSda ? 4 : h+p+1; sL = h+p+1; cF = h+1; cL = 2*h+p; dT = 2*h+p; eScl = 1; eSda = 1;
      end
      2: begin
        sF = (prevSda != ~b) ? 4 : 0; sL = sF; cF = h+1; cL = 2*h+1; dT = 2*h+1; eScl = 1; eSda = ~b;
      end
      default: begin
        sF = prevSda ? 2*h+3 : 4; sL = 2*h+3; cF = h+1; cL = h+1; dT = 2*h+3; eScl = 0; eSda = 0;
      end
    endcase
  endtask

  // op 4 raises start and stop together, op 5 raises write and stop together (R10)
  // injKind 1 raises start and stop strobes mid-run, 2 moves divSel mid-run
  task automatic runOp(input int op, input logic b, input logic [2:0] sel,
                       input int injKind, input int injAt, input string req);
    int p, h, eOp, sF, sL, cF, cL, dT;
    int gSF, gSL, gCF, gCL, gDT, dones, busyBad;
    logic eScl, eSda, pSda, pScl;
    gSF = 0; gSL = 0; gCF = 0; gCL = 0; gDT = 0; dones = 0; busyBad = 0;
    p = benchDiv(sel); h = p / 2;
    eOp = (op == 4) ? 0 : ((op == 5) ? 2 : op);
    @(negedge clk);
    pSda = sdaDriveLow; pScl = sclDriveLow;
    expectTimes(eOp, h, p, sdaDriveLow, b, sF, sL, cF, cL, dT, eScl, eSda);
    divSel = sel; wrBit = b;
    cmdStart   = (op == 0 || op == 4);
    cmdRestart = (op == 1);
    cmdWrite   = (op == 2 || op == 5);
    cmdStop    = (op == 3 || op == 4 || op == 5);
    for (int t = 1; t <= 4000; t++) begin
      @(negedge clk);
      if (sdaDriveLow !== pSda) begin if (gSF == 0) gSF = t; gSL = t; pSda = sdaDriveLow; end
      if (sclDriveLow !== pScl) begin if (gCF == 0) gCF = t; gCL = t; pScl = sclDriveLow; end
      if (done === 1'b1) begin dones++; if (gDT == 0) gDT = t; end
      else if (busy !== 1'b1) busyBad++;
      cmdStart = 0; cmdRestart = 0; cmdWrite = 0; cmdStop = 0;
      if (injKind == 1 && t == injAt) begin cmdStart = 1; cmdStop = 1; end
      if (injKind == 2 && t == injAt) divSel = 3'd0;
      if (gDT != 0) break;
    end
    @(negedge clk);
    if (done === 1'b1) dones++;
    chk(req, "sda first edge", gSF, sF);
    chk(req, "sda last edge", gSL, sL);
    chk(req, "scl first edge", gCF, cF);
    chk(req, "scl last edge", gCL, cL);
    chk(req, "done time", gDT, dT);
    chk(req, "scl end level", int'(sclDriveLow), int'(eScl));
    chk(req, "sda end level", int'(sdaDriveLow), int'(eSda));
    chk("R7", "done pulses", dones, 1);
    chk("R7", "busy gaps", busyBad, 0);
    chk("R7", "busy after done", int'(busy), 0);
  endtask

  initial begin
    #750us;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "scl in reset", int'(sclDriveLow), 0);
    chk("R1", "sda in reset", int'(sdaDriveLow), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "scl after reset", int'(sclDriveLow), 0);
    chk("R1", "sda after reset", int'(sdaDriveLow), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);

    for (int i = 0; i < 10; i++) begin
      logic [6:0] v;
      string tag;
      v = VEC[i];
      case (v[6:4])
        3'd0: tag = "R3 R2";
        3'd1: tag = "R5 R2";
        3'd2: tag = "R4 R2";
        default: tag = "R6 R2";
      endcase
      runOp(int'(v[6:4]), v[3], v[2:0], 0, 0, tag);
    end

    // Priority with bus released: start beats stop
    runOp(4, 1'b0, 3'd2, 0, 0, "R10 start");
    // Priority with SCL low: write beats stop
    runOp(5, 1'b1, 3'd2, 0, 0, "R10 write");
    // Strobes while busy are ignored
    runOp(1, 1'b0, 3'd2, 1, 5, "R8 restart");
    // Divisor change while busy has no effect
    runOp(2, 1'b0, 3'd2, 2, 2, "R9 write");
    runOp(3, 1'b0, 3'd3, 2, 10, "R9 stop");

    // Reset in the middle of a start, after SDA has fallen
    @(negedge clk);
    divSel = 3'd2; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    repeat (30) @(negedge clk);
    chk("R3", "sda low before reset", int'(sdaDriveLow), 1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "scl after mid reset", int'(sclDriveLow), 0);
    chk("R1", "sda after mid reset", int'(sdaDriveLow), 0);
    chk("R1", "busy after mid reset", int'(busy), 0);
    chk("R1", "done after mid reset", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule